// File: doc/BRIEF.md
# Multi-Domain Transfer Reset Sequencer

This block sequences reset and enable for a transfer engine whose logic spans a control clock and two data clocks. The data moves from a source-side domain to a destination-side domain. The sequencer runs on the control clock. It sends a reset request and an enable request into each data domain over two-flop synchronizers. Each data domain counts how long it has been in reset on its own clock. It returns a registered "held long enough" flag, which is resynchronized into the control domain.

Clearing the run input aborts a transfer, and the block then waits in a drain state until the engine reports idle. Only then does it reuse the power-up reset sequence to wipe stale state from the aborted transfer. All resets are held until every data domain has seen its reset for at least the hold count on its own clock, so the slowest domain sets the length. The destination side is released first. The source side is released only after the control domain has seen the destination leave reset.

After the sequence, the block sits in a ready state with a done flag raised, and a new transfer may start from there. Pause drops the data-side enables and applies no reset. On resume both sides carry on from their held state.

Top module: `xfer_reset_seq`

## Requirements
- R1: While the control reset is asserted, `src_rst` and `dst_rst` are 1, and `src_en`, `dst_en` and `seq_done` are 0.
- R2: After the control reset is released, a reset sequence runs with no other input. It ends with exactly one release of each domain reset and with `seq_done` high.
- R3: Each domain reset stays high for at least HOLD_CYC (default 4) cycles of that domain's own clock before it falls.
- R4: `dst_rst` falls before `src_rst`. When `src_rst` falls, `dst_rst` is already 0.
- R5: When the sequence is complete and `run_en` is 0, the block stays ready. `seq_done` stays 1, both resets stay 0 and both enables stay 0.
- R6: Setting `run_en` to 1 while ready starts a transfer. Both enables become 1 and `seq_done` becomes 0.
- R7: `run_en` has no effect while a reset sequence is in progress. An enable is never 1 while its own domain reset is 1.
- R8: `pause_req`=1 while running drops both enables and asserts no reset. `pause_req`=0 restores both enables.
- R9: Clearing `run_en`, whether running or paused, drops both enables. No reset is asserted while `engine_idle` is 0.
- R10: Once `engine_idle` is 1 after an abort, a complete sequence runs, releasing each domain reset once, and ends with `seq_done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control domain clock |
| ctl_rst_n | input | 1 | Active-low control reset (also asynchronously asserts data-side reset) |
| run_en | input | 1 | Transfer run request; clearing it aborts |
| pause_req | input | 1 | Pause request while running |
| engine_idle | input | 1 | Engine has no outstanding bus work (control domain) |
| src_clk | input | 1 | Source data domain clock |
| src_rst | output | 1 | Source domain reset, synchronous to src_clk |
| src_en | output | 1 | Source domain enable, synchronous to src_clk |
| dst_clk | input | 1 | Destination data domain clock |
| dst_rst | output | 1 | Destination domain reset, synchronous to dst_clk |
| dst_en | output | 1 | Destination domain enable, synchronous to dst_clk |
| seq_done | output | 1 | Sequence complete; new transfer may start |

## Verification
The bench sweeps aborts from the running and paused states, with drain delays of 0 to 3 steps. In half of the runs it raises `run_en` again while the reset is still held. A design that resets before the engine is idle would show a reset during the drain window. One that releases the source first, or counts the hold on the wrong clock, would show a source-reset fall while `dst_rst` is still high, or a reset streak shorter than four cycles of the slow destination clock. A design that accepts an enable mid-sequence would raise an enable while its domain is still in reset.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_PAUSE, ST_DRAIN, ST_HOLD, ST_REL_DST, ST_REL_SRC, ST_READY
  } seq_state_e;

  // True once a reset-held counter has reached the required count.
  function automatic logic hold_reached(input int unsigned cnt, input int unsigned need);
    return cnt >= need;
  endfunction
endpackage

// File: rtl/xrs_bit_sync.sv
module xrs_bit_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{RST_VAL}};
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xrs_domain_port.sv
module xrs_domain_port #(
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic dclk,
  input  logic arst_n,
  input  logic rst_req,
  input  logic en_req,
  output logic drst,
  output logic den,
  output logic hold_ack
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          rst_s;
  logic          en_s;
  logic [CW-1:0] held_cnt;
  logic          ack_q;

  xrs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) rst_sync_i (
    .clk(dclk), .arst_n(arst_n), .d(rst_req), .q(rst_s));
  xrs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) en_sync_i (
    .clk(dclk), .arst_n(arst_n), .d(en_req), .q(en_s));

  always_ff @(posedge dclk or negedge arst_n) begin
    if (!arst_n) begin
      held_cnt <= '0;
      ack_q    <= 1'b0;
    end else begin
      if (!rst_s)
        held_cnt <= '0;
      else if (!xrs_pkg::hold_reached(32'(held_cnt), 32'(HOLD_CYC)))
        held_cnt <= held_cnt + CW'(1);
      ack_q <= rst_s && xrs_pkg::hold_reached(32'(held_cnt), 32'(HOLD_CYC));
    end
  end

  assign drst     = rst_s;
  assign den      = en_s & ~rst_s;
  assign hold_ack = ack_q;
endmodule

// File: rtl/xrs_ctl_fsm.sv
module xrs_ctl_fsm (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_en,
  input  logic                   pause_req,
  input  logic                   engine_idle,
  input  logic                   src_ack,
  input  logic                   dst_ack,
  output xrs_pkg::seq_state_e    state,
  output logic                   src_rst_req,
  output logic                   dst_rst_req,
  output logic                   en_req,
  output logic                   seq_done
);
  import xrs_pkg::*;

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:     if (!run_en) nxt = ST_DRAIN; else if (pause_req) nxt = ST_PAUSE;
      ST_PAUSE:   if (!run_en) nxt = ST_DRAIN; else if (!pause_req) nxt = ST_RUN;
      ST_DRAIN:   if (engine_idle) nxt = ST_HOLD;
      ST_HOLD:    if (src_ack && dst_ack) nxt = ST_REL_DST;
      ST_REL_DST: if (!dst_ack) nxt = ST_REL_SRC;
      ST_REL_SRC: if (!src_ack) nxt = ST_READY;
      ST_READY:   if (run_en) nxt = ST_RUN;
      default:    nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_HOLD;
      src_rst_req <= 1'b1;
      dst_rst_req <= 1'b1;
      en_req      <= 1'b0;
      seq_done    <= 1'b0;
    end else begin
      state       <= nxt;
      src_rst_req <= (nxt == ST_HOLD) || (nxt == ST_REL_DST);
      dst_rst_req <= (nxt == ST_HOLD);
      en_req      <= (nxt == ST_RUN);
      seq_done    <= (nxt == ST_READY);
    end
  end
endmodule

// File: rtl/xfer_reset_seq.sv
module xfer_reset_seq #(
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic ctl_clk,
  input  logic ctl_rst_n,
  input  logic run_en,
  input  logic pause_req,
  input  logic engine_idle,
  input  logic src_clk,
  output logic src_rst,
  output logic src_en,
  input  logic dst_clk,
  output logic dst_rst,
  output logic dst_en,
  output logic seq_done
);
  xrs_pkg::seq_state_e state;
  logic src_rst_req, dst_rst_req, en_req;
  logic src_ack_d, dst_ack_d;
  logic src_ack_c, dst_ack_c;

  xrs_ctl_fsm fsm_i (
    .clk(ctl_clk), .rst_n(ctl_rst_n), .run_en(run_en), .pause_req(pause_req),
    .engine_idle(engine_idle), .src_ack(src_ack_c), .dst_ack(dst_ack_c),
    .state(state), .src_rst_req(src_rst_req), .dst_rst_req(dst_rst_req),
    .en_req(en_req), .seq_done(seq_done));

  xrs_domain_port #(.HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)) src_port_i (
    .dclk(src_clk), .arst_n(ctl_rst_n), .rst_req(src_rst_req), .en_req(en_req),
    .drst(src_rst), .den(src_en), .hold_ack(src_ack_d));

  xrs_domain_port #(.HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)) dst_port_i (
    .dclk(dst_clk), .arst_n(ctl_rst_n), .rst_req(dst_rst_req), .en_req(en_req),
    .drst(dst_rst), .den(dst_en), .hold_ack(dst_ack_d));

  xrs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) src_ack_sync_i (
    .clk(ctl_clk), .arst_n(ctl_rst_n), .d(src_ack_d), .q(src_ack_c));
  xrs_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) dst_ack_sync_i (
    .clk(ctl_clk), .arst_n(ctl_rst_n), .d(dst_ack_d), .q(dst_ack_c));
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker (
  input logic                clk,
  input logic                rst_n,
  input logic                engine_idle,
  input xrs_pkg::seq_state_e state,
  input logic                src_rst_req,
  input logic                dst_rst_req,
  input logic                en_req,
  input logic                src_ack_c,
  input logic                dst_ack_c,
  input logic                seq_done
);
  import xrs_pkg::*;

  a_r9_idle_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dst_rst_req) |-> $past(engine_idle));

  a_r3_hold_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dst_rst_req) |-> ($past(src_ack_c) && $past(dst_ack_c)));

  a_r4_dest_out_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_rst_req) |-> (!dst_rst_req && !dst_ack_c));

  a_r8_pause_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSE) |-> (!en_req && !src_rst_req && !dst_rst_req));

  a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (!src_rst_req && !dst_rst_req && !en_req));

  a_r7_no_enable_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD || state == ST_REL_DST || state == ST_REL_SRC) |-> !en_req);
endmodule

bind xfer_reset_seq xrs_checker chk_i (
  .clk(ctl_clk), .rst_n(ctl_rst_n), .engine_idle(engine_idle), .state(state),
  .src_rst_req(src_rst_req), .dst_rst_req(dst_rst_req), .en_req(en_req),
  .src_ack_c(src_ack_c), .dst_ack_c(dst_ack_c), .seq_done(seq_done));

// File: tb/xfer_reset_seq_tb_top.sv
`timescale 1ns/1ps
module xfer_reset_seq_tb_top;
  localparam int HOLD = 4;

  logic ctl_clk = 0, src_clk = 0, dst_clk = 0;
  logic ctl_rst_n = 0, run_en = 0, pause_req = 0, engine_idle = 1;
  logic src_rst, src_en, dst_rst, dst_en, seq_done;

  int checks = 0, fails = 0;
  int src_falls = 0, dst_falls = 0, overlap = 0;
  int src_streak = 0, dst_streak = 0;
  logic src_prev = 1, dst_prev = 1;
  bit done_run = 0;

  always #2 ctl_clk = ~ctl_clk;   // 250 MHz
  always #3 src_clk = ~src_clk;
  always #7 dst_clk = ~dst_clk;   // slowest domain

  xfer_reset_seq #(.HOLD_CYC(HOLD)) dut_i (
    .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .run_en(run_en), .pause_req(pause_req),
    .engine_idle(engine_idle), .src_clk(src_clk), .src_rst(src_rst), .src_en(src_en),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_en(dst_en), .seq_done(seq_done));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Source domain monitor: R3 hold length, R4 order, R7 overlap
  always @(negedge src_clk) if (ctl_rst_n && !done_run) begin
    if (src_en && src_rst) overlap++;
    if (src_rst) src_streak++;
    else if (src_prev) begin
      check(src_streak >= HOLD, "R3 src reset hold", src_streak, HOLD);
      check(dst_rst == 1'b0, "R4 dst released before src", int'(dst_rst), 0);
      src_falls++;
      src_streak = 0;
    end
    src_prev = src_rst;
  end

  // Destination domain monitor
  always @(negedge dst_clk) if (ctl_rst_n && !done_run) begin
    if (dst_en && dst_rst) overlap++;
    if (dst_rst) dst_streak++;
    else if (dst_prev) begin
      check(dst_streak >= HOLD, "R3 dst reset hold", dst_streak, HOLD);
      dst_falls++;
      dst_streak = 0;
    end
    dst_prev = dst_rst;
  end

  task automatic ctl_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge ctl_clk);
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge ctl_clk);
      if (seq_done) seen = 1;
    end
    check(seen, tag, int'(seen), 1);
  endtask

  task automatic finish_run();
    done_run = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    ctl_wait(5);
    check(src_rst && dst_rst && !src_en && !dst_en && !seq_done, "R1 reset state",
          {src_rst, dst_rst, src_en, dst_en, seq_done}, 5'b11000);
    run_en = 1;                       // R7: held during startup sequence
    ctl_rst_n = 1;
    wait_done("R2 startup reaches done");
    check(src_falls == 1 && dst_falls == 1, "R2 one release per domain",
          src_falls * 10 + dst_falls, 11);
    ctl_wait(30);
    check(src_en && dst_en && !seq_done, "R6 running after startup",
          {src_en, dst_en, seq_done}, 3'b110);

    for (int mode = 0; mode < 2; mode++) begin
      for (int d = 0; d < 4; d++) begin
        int sf, df;
        run_en = 1;
        ctl_wait(30);
        check(src_en && dst_en && !seq_done, "R6 transfer running",
              {src_en, dst_en, seq_done}, 3'b110);
        if (mode == 1) begin
          pause_req = 1; ctl_wait(30);
          check(!src_en && !dst_en && !src_rst && !dst_rst, "R8 pause no reset",
                {src_en, dst_en, src_rst, dst_rst}, 0);
          pause_req = 0; ctl_wait(30);
          check(src_en && dst_en, "R8 resume restores enables", {src_en, dst_en}, 3);
          pause_req = 1; ctl_wait(30);
        end
        sf = src_falls; df = dst_falls;
        engine_idle = 0;
        run_en = 0;
        ctl_wait(30 + d * 20);
        check(!src_en && !dst_en && !src_rst && !dst_rst && !seq_done,
              "R9 drain waits for idle", {src_en, dst_en, src_rst, dst_rst, seq_done}, 0);
        pause_req = 0;
        engine_idle = 1;
        if (d % 2 == 1) begin
          ctl_wait(3);
          run_en = 1;                 // R7: ignored mid-sequence
        end
        wait_done("R10 abort sequence completes");
        check(src_falls == sf + 1 && dst_falls == df + 1, "R10 one release each",
              (src_falls - sf) * 10 + (dst_falls - df), 11);
        ctl_wait(30);
        if (d % 2 == 1)
          check(src_en && dst_en && !seq_done, "R6 new transfer after sequence",
                {src_en, dst_en, seq_done}, 3'b110);
        else
          check(seq_done && !src_en && !dst_en && !src_rst && !dst_rst, "R5 stays ready",
                {seq_done, src_en, dst_en, src_rst, dst_rst}, 5'b10000);
      end
    end
    check(overlap == 0, "R7 no enable while in reset", overlap, 0);
    finish_run();
  end
endmodule